// File: doc/BRIEF.md
# Dual-Port RAM with Collision Monitor

This block is a synchronous two-port RAM with an access monitor that never gets in the way. Port A and port B can each read or write any word in every clock cycle. Every access is carried out exactly as issued, and the monitor never stalls, blocks or reorders one. Alongside the array, a monitor compares the two ports' addresses and access kinds in the same cycle. When an overlap could have produced questionable data, it raises a one-cycle flag on the affected port.

The flag is steered by the pair of access kinds:

- Two reads of one word are harmless and raise nothing.
- A read against a write is treated as a valid write and a suspect read, so only the reader is flagged.
- Two writes to one word flag both ports. Port A's data is the value kept.

A read that meets a write returns the word's previous contents. Each flag is registered so that it appears in the same cycle as that port's read data. Software on each side can then discard or retry the transfer, or move its traffic to another region.

Top module: `dual_port_collision_ram`

## Requirements
- R1: While reset is active and until the first access after it, both read-data outputs are zero and both collision flags are low.
- R2: A read (enable 1, write-enable 0) presents the addressed word on that port's read data one clock edge after it is issued.
- R3: A write (enable 1, write-enable 1) stores its data, and a later read from either port returns it. Accesses to different addresses on the two ports all complete in the same cycle.
- R4: Two reads of the same address in one cycle both return that word, and neither collision flag rises.
- R5: A write on one port and a read of the same address on the other stores the written data. The reader receives the word's previous contents and its flag is high. The writer's flag stays low.
- R6: Two writes to the same address in one cycle raise both flags, and the word then holds port A's data.
- R7: When both ports are enabled but address different words, no flag rises, whatever the access kinds.
- R8: A flag is high for exactly the one cycle in which that port's read data for the colliding access is presented. A port that was idle in the previous cycle has its flag low.
- R9: A port's read data holds its value in every cycle that follows a cycle in which that port did not read (idle or writing).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_en | input | 1 | Port A access enable |
| a_we | input | 1 | Port A write (1) or read (0) |
| a_addr | input | AW | Port A word address |
| a_wdata | input | DW | Port A write data |
| a_rdata | output | DW | Port A read data |
| a_coll | output | 1 | Port A collision flag, active high |
| b_en | input | 1 | Port B access enable |
| b_we | input | 1 | Port B write (1) or read (0) |
| b_addr | input | AW | Port B word address |
| b_wdata | input | DW | Port B write data |
| b_rdata | output | DW | Port B read data |
| b_coll | output | 1 | Port B collision flag, active high |

## Verification
Every internal fault of this block shows at the ports one clock edge after the access that exposes it.

- A wrong word in the array appears on the next read of that address from either port.
- A broken write-priority rule appears as port B's value surviving a double write.
- A read-after-write ordering error shows as new data where old contents were expected.
- A fault in the access-kind decode or the address compare shows as a flag raised or missing in the very cycle the read data arrives.

Random traffic confined to a few addresses produces every access-kind pairing many times. Directed cases pin down the two-write priority and the old-data return.

// File: rtl/dpcd_pkg.sv
package dpcd_pkg;

  typedef enum logic [1:0] {
    ACC_IDLE  = 2'b00,
    ACC_READ  = 2'b01,
    ACC_WRITE = 2'b10
  } acc_kind_e;

  function automatic acc_kind_e classify(input logic en, input logic we);
    if (!en)     return ACC_IDLE;
    else if (we) return ACC_WRITE;
    else         return ACC_READ;
  endfunction

  typedef struct packed {
    logic flag_a;
    logic flag_b;
  } coll_pair_t;

endpackage

// File: rtl/dpcd_rst_sync.sv
module dpcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_core_n = sync_q[STAGES-1];
endmodule

// File: rtl/dpcd_mem_array.sv
module dpcd_mem_array #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0] word_en;

  logic a_wr, b_wr, a_rd, b_rd;
  assign a_wr = a_en &  a_we;
  assign b_wr = b_en &  b_we;
  assign a_rd = a_en & ~a_we;
  assign b_rd = b_en & ~b_we;

  // Per-word next state: port A has priority over port B on the same word.
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic hit_a, hit_b;
    assign hit_a = a_wr && (a_addr == AW'(i));
    assign hit_b = b_wr && (b_addr == AW'(i));

    always_comb begin
      word_en[i] = hit_a | hit_b;
      if (hit_a) mem_d[i] = a_wdata;
      else       mem_d[i] = b_wdata;
    end

    always_ff @(posedge clk) begin
      if (word_en[i]) mem_q[i] <= mem_d[i];
    end
  end

  // Read-first registered outputs: sample the contents before this edge's write.
  logic [DW-1:0] a_rd_d, b_rd_d;

  always_comb begin
    a_rd_d = mem_q[a_addr];
    b_rd_d = mem_q[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata <= '0;
      b_rdata <= '0;
    end else begin
      if (a_rd) a_rdata <= a_rd_d;
      if (b_rd) b_rdata <= b_rd_d;
    end
  end
endmodule

// File: rtl/dpcd_collision_det.sv
module dpcd_collision_det
  import dpcd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  output logic          a_coll,
  output logic          b_coll
);
  acc_kind_e  kind_a, kind_b;
  logic       same_word;
  coll_pair_t flags_d, flags_q;

  always_comb begin
    kind_a    = classify(a_en, a_we);
    kind_b    = classify(b_en, b_we);
    same_word = (a_addr == b_addr);
    flags_d   = '0;
    if (same_word) begin
      unique case ({kind_a, kind_b})
        {ACC_WRITE, ACC_WRITE}: flags_d = '{flag_a: 1'b1, flag_b: 1'b1};
        {ACC_WRITE, ACC_READ}:  flags_d = '{flag_a: 1'b0, flag_b: 1'b1};
        {ACC_READ,  ACC_WRITE}: flags_d = '{flag_a: 1'b1, flag_b: 1'b0};
        default:                flags_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign a_coll = flags_q.flag_a;
  assign b_coll = flags_q.flag_b;
endmodule

// File: rtl/dual_port_collision_ram.sv
module dual_port_collision_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_en,
  input  logic          a_we,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_coll,
  input  logic          b_en,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_coll
);
  logic rst_core_n;

  dpcd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  dpcd_mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .a_en    (a_en),
    .a_we    (a_we),
    .a_addr  (a_addr),
    .a_wdata (a_wdata),
    .a_rdata (a_rdata),
    .b_en    (b_en),
    .b_we    (b_we),
    .b_addr  (b_addr),
    .b_wdata (b_wdata),
    .b_rdata (b_rdata)
  );

  dpcd_collision_det #(.AW(AW)) u_det (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .a_en   (a_en),
    .a_we   (a_we),
    .a_addr (a_addr),
    .b_en   (b_en),
    .b_we   (b_we),
    .b_addr (b_addr),
    .a_coll (a_coll),
    .b_coll (b_coll)
  );
endmodule

// File: rtl/dpcd_checker.sv
module dpcd_checker #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          a_en,
  input logic          a_we,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          a_coll,
  input logic          b_en,
  input logic          b_we,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          b_coll
);
  // R1
  always_comb begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!a_coll && !b_coll && a_rdata == '0 && b_rdata == '0);
    end
  end

  // R4
  two_reads_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && !a_we && b_en && !b_we && a_addr == b_addr) |=> (!a_coll && !b_coll));

  // R5
  a_writes_b_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && b_en && !b_we && a_addr == b_addr) |=> (b_coll && !a_coll));

  // R5
  b_writes_a_reads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && b_we && a_en && !a_we && a_addr == b_addr) |=> (a_coll && !b_coll));

  // R6
  two_writes_both_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we && b_en && b_we && a_addr == b_addr) |=> (a_coll && b_coll));

  // R7
  distinct_addr_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_addr != b_addr) |=> (!a_coll && !b_coll));

  // R8
  idle_a_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !a_en |=> !a_coll);

  // R8
  idle_b_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !b_en |=> !b_coll);

  // R9
  a_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_en && !a_we) |=> $stable(a_rdata));

  // R9
  b_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(b_en && !b_we) |=> $stable(b_rdata));

  // R3
  write_then_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en && a_we) ##1 (a_en && !a_we && a_addr == $past(a_addr) &&
                        !(b_en && b_we && b_addr == a_addr))
    |=> (a_rdata == $past(a_wdata, 2)));
endmodule

bind dual_port_collision_ram dpcd_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_core_n),
  .a_en    (a_en),
  .a_we    (a_we),
  .a_addr  (a_addr),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .a_coll  (a_coll),
  .b_en    (b_en),
  .b_we    (b_we),
  .b_addr  (b_addr),
  .b_wdata (b_wdata),
  .b_rdata (b_rdata),
  .b_coll  (b_coll)
);

// File: tb/tb_dual_port_collision_ram.sv
module tb_dual_port_collision_ram;
  localparam int AW    = 4;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          a_en, a_we, b_en, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic          a_coll, b_coll;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_ra, exp_rb;
  logic          exp_ca, exp_cb;

  always #5 clk = ~clk;

  dual_port_collision_ram #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata),
    .a_rdata(a_rdata), .a_coll(a_coll),
    .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata),
    .b_rdata(b_rdata), .b_coll(b_coll)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic string tag_for(input logic ae, input logic aw, input logic be,
                                    input logic bw, input logic [AW-1:0] aa,
                                    input logic [AW-1:0] ba);
    if (!(ae && be) || aa != ba) return "R7";
    if (aw && bw)                return "R6";
    if (aw || bw)                return "R5";
    return "R4";
  endfunction

  // Compute expected outputs for the access being driven, then update the model.
  task automatic predict();
    if (a_en && !a_we) exp_ra = model[a_addr];
    if (b_en && !b_we) exp_rb = model[b_addr];
    exp_ca = a_en && b_en && a_addr == b_addr && (b_we || (a_we && b_we)) && !(a_we && !b_we);
    exp_cb = a_en && b_en && a_addr == b_addr && a_we;
    if (b_en && b_we) model[b_addr] = b_wdata;
    if (a_en && a_we) model[a_addr] = a_wdata;   // A wins on the same word
  endtask

  task automatic cycle(input logic ae, input logic aw, input logic [AW-1:0] aa,
                       input logic [DW-1:0] ad, input logic be, input logic bw,
                       input logic [AW-1:0] ba, input logic [DW-1:0] bd);
    string t;
    a_en = ae; a_we = aw; a_addr = aa; a_wdata = ad;
    b_en = be; b_we = bw; b_addr = ba; b_wdata = bd;
    t = tag_for(ae, aw, be, bw, aa, ba);
    predict();
    @(negedge clk);
    chk(a_rdata == exp_ra, (ae && !aw) ? "R2" : "R9", int'(a_rdata), int'(exp_ra));
    chk(b_rdata == exp_rb, (be && !bw) ? "R2" : "R9", int'(b_rdata), int'(exp_rb));
    chk(a_coll == exp_ca, t, int'(a_coll), int'(exp_ca));
    chk(b_coll == exp_cb, t, int'(b_coll), int'(exp_cb));
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    rst_n = 1'b0;
    a_en = 0; a_we = 0; a_addr = '0; a_wdata = '0;
    b_en = 0; b_we = 0; b_addr = '0; b_wdata = '0;
    exp_ra = '0; exp_rb = '0; exp_ca = 0; exp_cb = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(a_rdata == '0 && b_rdata == '0, "R1", int'({a_rdata, b_rdata}), 0);
    chk(!a_coll && !b_coll, "R1", int'({a_coll, b_coll}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(a_rdata == '0 && b_rdata == '0 && !a_coll && !b_coll, "R1",
        int'({a_rdata, b_rdata}), 0);

    // R3: fill every word, two ports at once on different addresses
    for (int i = 0; i < DEPTH; i += 2)
      cycle(1, 1, AW'(i), DW'(8'h30 + i), 1, 1, AW'(i + 1), DW'(8'h30 + i + 1));
    // R3: read back crosswise
    for (int i = 0; i < DEPTH; i += 2)
      cycle(1, 0, AW'(i + 1), '0, 1, 0, AW'(i), '0);

    // R4: two reads of one word
    cycle(1, 0, 4'd5, '0, 1, 0, 4'd5, '0);
    // R5: A writes, B reads same word: B gets old data, flag on B only
    cycle(1, 1, 4'd6, 8'hA6, 1, 0, 4'd6, '0);
    // R5: B writes, A reads
    cycle(1, 0, 4'd7, '0, 1, 1, 4'd7, 8'hB7);
    // R6: two writes, A wins
    cycle(1, 1, 4'd8, 8'hAA, 1, 1, 4'd8, 8'hBB);
    // R8: flags drop the next cycle; R6 check stored value
    cycle(1, 0, 4'd8, '0, 1, 0, 4'd8, '0);
    chk(a_rdata == 8'hAA, "R6", int'(a_rdata), 8'hAA);
    // R8: consecutive collisions flag in consecutive cycles
    cycle(1, 1, 4'd2, 8'h11, 1, 0, 4'd2, '0);
    cycle(1, 1, 4'd2, 8'h22, 1, 0, 4'd2, '0);
    cycle(0, 0, 4'd2, '0, 1, 0, 4'd2, '0);
    // R7: different addresses, all kinds
    cycle(1, 1, 4'd3, 8'h33, 1, 1, 4'd4, 8'h44);
    cycle(1, 0, 4'd3, '0, 1, 1, 4'd9, 8'h99);

    // Random traffic focused on a few words to provoke collisions
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ra, rb;
      ra = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 3);
      rb = (($urandom % 4) == 0) ? AW'($urandom) : AW'($urandom % 3);
      cycle(($urandom % 5) != 0, $urandom % 2, ra, DW'($urandom),
            ($urandom % 5) != 0, $urandom % 2, rb, DW'($urandom));
    end

    // R3: final sweep of the whole array against the model
    for (int i = 0; i < DEPTH; i++)
      cycle(1, 0, AW'(i), '0, 0, 0, '0, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule